// File: doc/BRIEF.md
# Triggered Sample Capture and Serial Dump

This core is a small embedded logic analyzer that sits next to the logic it observes and shares its clock. It watches a wide channel bus and waits for a trigger. The trigger arms capture once and stays armed. From then on, the core writes one snapshot of the whole bus into on-chip storage on every clock cycle where the sample-enable input is high. The write address moves only on those cycles.

When the last storage entry has been written, capture stops. The core then reads the stored snapshots back in capture order and sends each one over a built-in asynchronous serial transmitter as a run of bytes, most significant byte first. After the final byte, the core goes quiet and stays quiet until it is reset. A host on the other end of the line rebuilds the snapshots from the byte stream.

The channel width, storage depth, clock frequency and line rate are parameters. The bit period is derived from the clock frequency and the line rate.

Top module: `la_probe_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge clears the trigger latch, the write address and the readout sequencer. `ser_tx` is high during and after reset until a readout begins.
- R2: The trigger is sticky. One cycle of `trig_in` high arms capture for good. A snapshot is stored on the trigger cycle itself if `smp_en` is also high in that cycle.
- R3: Before the first trigger cycle, no snapshot is stored, whatever the value of `smp_en`.
- R4: While armed, a cycle with `smp_en` low stores nothing and does not advance the write address, so stored entries are consecutive in enabled-cycle order.
- R5: Once DEPTH snapshots are stored, capture stops. Later values on `chan_in`, `trig_in` and `smp_en` do not change the stored data.
- R6: Serial readout starts by itself only after the storage is full. It sends the entries from address 0 up to address DEPTH-1.
- R7: Each entry is sent as CHANNELS/8 bytes. The first byte is bits CHANNELS-1 down to CHANNELS-8, and the last byte is bits 7..0.
- R8: Each byte is framed as one start bit of 0, then eight data bits with bit 0 first, then one stop bit of 1. The line idles at 1.
- R9: Every bit on `ser_tx` lasts exactly CLK_HZ/BAUD clock cycles (integer division).
- R10: After the last byte of the last entry, `ser_tx` stays high and the core ignores `trig_in` and `smp_en` until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, also the sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | 1 | Trigger; one high cycle arms capture |
| smp_en | input | 1 | Per-cycle sample enable while armed |
| chan_in | input | CHANNELS | Channel bus being observed |
| ser_tx | output | 1 | Asynchronous serial output line, idle high |

## Verification
The assertions check the cycle-level rules on every cycle:
- the trigger latch never drops once set;
- the write address holds on cycles without a store;
- no store happens once the storage is full;
- the transmitter is never busy before the storage is full, and is only started while it is idle;
- the done state persists with the line high.

The following can only be shown by the bench's scenarios, which decode the serial stream:
- that the stored data matches the enabled, post-trigger channel values in order;
- the byte order and bit order;
- the exact bit period;
- that a reset really disarms a half-finished capture.

// File: rtl/la_probe_pkg.sv
// Package: shared types for the probe core.
// Assumes: nothing beyond the 1800-2017 language.
package la_probe_pkg;

    // Readout sequencer states.
    typedef enum logic [2:0] {
        RO_WAIT  = 3'd0,   // storage not yet full
        RO_FETCH = 3'd1,   // read address presented to storage
        RO_LOAD  = 3'd2,   // read data valid, latch word
        RO_SEND  = 3'd3,   // pulse start to the transmitter
        RO_HOLD  = 3'd4,   // wait for the transmitter to finish
        RO_DONE  = 3'd5    // all bytes sent, idle until reset
    } ro_state_t;

endpackage

// File: rtl/la_capture.sv
// Module: la_capture
// Holds the sticky trigger latch and the capture write address, and
// flags when the last storage entry has been written.
// Assumes: DEPTH >= 2; synchronous active-low reset.
module la_capture #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_in,
    input  logic          smp_en,
    output logic          armed,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          full
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic          armed_q;
    logic [AW-1:0] addr_q;
    logic          full_q;

    // Store on armed (or trigger-now) enabled cycles until full.
    assign wr_en   = (armed_q | trig_in) & smp_en & ~full_q;
    assign armed   = armed_q;
    assign wr_addr = addr_q;
    assign full    = full_q;

    // Sticky trigger latch.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed_q <= 1'b0;
        else if (trig_in) armed_q <= 1'b1;
    end

    // Write address advance and full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            full_q <= 1'b0;
        end else if (wr_en) begin
            if (addr_q == LAST) full_q <= 1'b1;
            else                addr_q <= addr_q + 1'b1;
        end
    end

endmodule

// File: rtl/la_sample_mem.sv
// Module: la_sample_mem
// Simple dual-port sample storage: one write port, one registered read port.
// Assumes: read data is valid the cycle after the address is presented.
module la_sample_mem #(
    parameter int W     = 128,
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        rdata <= mem_q[raddr];
    end

endmodule

// File: rtl/la_uart_tx.sv
// Module: la_uart_tx
// Asynchronous serial transmitter, one start bit, eight data bits
// (bit 0 first), one stop bit. Each bit lasts CLK_HZ/BAUD cycles.
// Assumes: start is only pulsed while busy is low; CLK_HZ/BAUD >= 2.
module la_uart_tx #(
    parameter int CLK_HZ = 200_000_000,
    parameter int BAUD   = 38_400,
    localparam int DIV = CLK_HZ / BAUD,
    localparam int CW  = $clog2(DIV + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] data,
    output logic       busy,
    output logic       txd
);
    logic [9:0]    frame_q;
    logic [CW-1:0] cnt_q;
    logic [3:0]    bit_q;
    logic          busy_q;

    assign busy = busy_q;
    assign txd  = busy_q ? frame_q[0] : 1'b1;

    // Frame load, bit timing and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            frame_q <= '1;
            cnt_q   <= '0;
            bit_q   <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q  <= 1'b1;
                frame_q <= {1'b1, data, 1'b0};
                cnt_q   <= '0;
                bit_q   <= '0;
            end
        end else if (cnt_q == CW'(DIV - 1)) begin
            cnt_q <= '0;
            if (bit_q == 4'd9) begin
                busy_q <= 1'b0;
            end else begin
                frame_q <= {1'b1, frame_q[9:1]};
                bit_q   <= bit_q + 1'b1;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/la_readout.sv
// Module: la_readout
// Once storage is full, reads entries 0..DEPTH-1 and hands each entry
// to the transmitter as W/8 bytes, most significant byte first.
// Assumes: W is a multiple of 8; storage read latency of one cycle.
module la_readout #(
    parameter int W     = 128,
    parameter int DEPTH = 512,
    localparam int AW    = $clog2(DEPTH),
    localparam int BYTES = W / 8,
    localparam int BW    = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          full,
    output logic [AW-1:0] rd_addr,
    input  logic [W-1:0]  rd_data,
    output logic          tx_start,
    output logic [7:0]    tx_byte,
    input  logic          tx_busy,
    output logic          done
);
    import la_probe_pkg::*;

    ro_state_t     state_q;
    logic [AW-1:0] addr_q;
    logic [BW-1:0] byte_q;
    logic [W-1:0]  word_q;

    assign rd_addr  = addr_q;
    assign tx_start = (state_q == RO_SEND);
    assign tx_byte  = word_q[W-1 -: 8];
    assign done     = (state_q == RO_DONE);

    // Readout sequencing over entries and bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RO_WAIT;
            addr_q  <= '0;
            byte_q  <= '0;
            word_q  <= '0;
        end else begin
            case (state_q)
                RO_WAIT:  if (full) state_q <= RO_FETCH;
                RO_FETCH: state_q <= RO_LOAD;
                RO_LOAD: begin
                    word_q  <= rd_data;
                    byte_q  <= '0;
                    state_q <= RO_SEND;
                end
                RO_SEND:  state_q <= RO_HOLD;
                RO_HOLD: if (!tx_busy) begin
                    if (byte_q == BW'(BYTES - 1)) begin
                        if (addr_q == AW'(DEPTH - 1)) begin
                            state_q <= RO_DONE;
                        end else begin
                            addr_q  <= addr_q + 1'b1;
                            state_q <= RO_FETCH;
                        end
                    end else begin
                        byte_q  <= byte_q + 1'b1;
                        word_q  <= word_q << 8;
                        state_q <= RO_SEND;
                    end
                end
                RO_DONE:  state_q <= RO_DONE;
                default:  state_q <= RO_WAIT;
            endcase
        end
    end

endmodule

// File: rtl/la_probe_core.sv
// Module: la_probe_core (top)
// Triggered capture of a channel bus into on-chip storage, followed by an
// automatic serial dump of the full storage.
// Assumes: CHANNELS multiple of 8; DEPTH a power of two >= 2;
// synchronous active-low reset; one clock for capture and transmit.
module la_probe_core #(
    parameter int CHANNELS = 128,
    parameter int DEPTH    = 512,
    parameter int CLK_HZ   = 200_000_000,
    parameter int BAUD     = 38_400
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trig_in,
    input  logic                smp_en,
    input  logic [CHANNELS-1:0] chan_in,
    output logic                ser_tx
);
    localparam int AW = $clog2(DEPTH);

    logic          armed;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic          full;
    logic [AW-1:0] rd_addr;
    logic [CHANNELS-1:0] rd_data;
    logic          tx_start;
    logic [7:0]    tx_byte;
    logic          tx_busy;
    logic          done;

    la_capture #(.DEPTH(DEPTH)) u_cap (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .smp_en(smp_en),
        .armed(armed), .wr_en(wr_en), .wr_addr(wr_addr), .full(full)
    );

    la_sample_mem #(.W(CHANNELS), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(chan_in),
        .raddr(rd_addr), .rdata(rd_data)
    );

    la_readout #(.W(CHANNELS), .DEPTH(DEPTH)) u_ro (
        .clk(clk), .rst_n(rst_n), .full(full), .rd_addr(rd_addr),
        .rd_data(rd_data), .tx_start(tx_start), .tx_byte(tx_byte),
        .tx_busy(tx_busy), .done(done)
    );

    la_uart_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .data(tx_byte),
        .busy(tx_busy), .txd(ser_tx)
    );

endmodule

// File: rtl/la_probe_checks.sv
// Module: la_probe_checks
// Cycle-level rules of the probe core, attached to the top by bind.
// Assumes: connected to the internal nets of la_probe_core.
module la_probe_checks #(
    parameter int AW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ser_tx,
    input logic          armed,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          full,
    input logic          tx_start,
    input logic          tx_busy,
    input logic          done
);
    // R2: trigger latch never drops without reset.
    p_sticky_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);

    // R4: no store means the write address holds.
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(wr_addr));

    // R5: nothing is written once storage is full.
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr_en);

    // R6: transmitter stays idle until storage is full.
    p_tx_after_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !full |-> !tx_busy);

    // R8: a byte is only started on an idle transmitter.
    p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> !tx_busy);

    // R10: done persists and the line stays high.
    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && ser_tx));

endmodule

bind la_probe_core la_probe_checks #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ser_tx(ser_tx), .armed(armed),
    .wr_en(wr_en), .wr_addr(wr_addr), .full(full), .tx_start(tx_start),
    .tx_busy(tx_busy), .done(done)
);

// File: tb/sim_la_probe_core.sv
// Bench: directed scenarios for la_probe_core, one task each.
// The divisor is made small so that a whole dump fits in the run.
module sim_la_probe_core;
    localparam int CH     = 32;
    localparam int DEPTH  = 8;
    localparam int CLK_HZ = 384_000;
    localparam int BAUD   = 38_400;
    localparam int DIV    = CLK_HZ / BAUD;
    localparam int BYTES  = CH / 8;
    localparam int WD_LIM = 150_000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig_in = 1'b0;
    logic          smp_en = 1'b0;
    logic [CH-1:0] chan_in = '0;
    logic          ser_tx;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [CH-1:0] exp_q [DEPTH];

    la_probe_core #(.CHANNELS(CH), .DEPTH(DEPTH), .CLK_HZ(CLK_HZ),
                    .BAUD(BAUD)) u0 (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .smp_en(smp_en),
        .chan_in(chan_in), .ser_tx(ser_tx)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD_LIM) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected <= %0d", cyc, WD_LIM);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req,
                       input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; trig_in = 1'b0; smp_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Line must stay high for n cycles.
    task automatic quiet(input int n, input string req);
        int lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (ser_tx !== 1'b1) lows++;
        end
        chk(lows == 0, req, lows, 0);
    endtask

    // Receive one frame; sample each bit in its middle.
    task automatic rx_byte(output logic [7:0] b, output int lowlen,
                           output logic stopb);
        logic s [10*DIV];
        int   t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (ser_tx !== 1'b0 && t < 50*DIV);
        s[0] = ser_tx;
        for (int i = 1; i < 10*DIV; i++) begin
            @(negedge clk);
            s[i] = ser_tx;
        end
        lowlen = 0;
        while (lowlen < 10*DIV && s[lowlen] == 1'b0) lowlen++;
        for (int k = 0; k < 8; k++) b[k] = s[(k+1)*DIV + DIV/2];
        stopb = s[9*DIV + DIV/2];
    endtask

    // Arm after pre idle-enable cycles, then store with gaps; skip
    // cycles with enable low. Fills exp_q in bench order.
    task automatic capture(input logic [CH-1:0] seed, input int pre,
                           input bit en_on_trig);
        int  n = 0;
        bit  arm = 0;
        logic [CH-1:0] v = seed;
        int  i = 0;
        for (int p = 0; p < pre; p++) begin
            @(negedge clk);
            v = {v[CH-2:0], v[CH-1] ^ v[CH-3]} ^ CH'(p);
            chan_in = v; smp_en = 1'b1; trig_in = 1'b0;
        end
        while (n < DEPTH) begin
            @(negedge clk);
            v = {v[CH-2:0], v[CH-1] ^ v[CH-3]} + 32'h1357_9bdf;
            chan_in = v;
            trig_in = (i == 0);
            smp_en  = (i == 0) ? en_on_trig : ((i % 3) != 1);
            if (trig_in) arm = 1;
            if (arm && smp_en) begin exp_q[n] = v; n++; end
            i++;
        end
        @(negedge clk);
        chan_in = ~v; trig_in = 1'b1; smp_en = 1'b1;
    endtask

    // Decode the whole dump and compare with exp_q.
    task automatic dump_check();
        logic [7:0] b;
        int   lowlen;
        logic stopb;
        for (int s = 0; s < DEPTH; s++) begin
            for (int k = 0; k < BYTES; k++) begin
                logic [7:0] e;
                e = 8'(exp_q[s] >> (8*(BYTES-1-k)));
                rx_byte(b, lowlen, stopb);
                chk(b == e, "R7 byte (R2 R4 R5 R6)", b, e);
                chk(stopb == 1'b1, "R8 stop bit", stopb, 1);
                if (b[0]) chk(lowlen == DIV, "R9 bit period", lowlen, DIV);
            end
        end
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(ser_tx == 1'b1, "R1 idle in reset", ser_tx, 1);
        rst_n = 1'b1; smp_en = 1'b1;
        quiet(20*DIV, "R3 no trigger no dump");
    endtask

    task automatic t_capture_dump();
        do_reset();
        capture(32'hA5C3_0F1E, 6, 1'b1);
        dump_check();
    endtask

    task automatic t_done_quiet();
        @(negedge clk);
        trig_in = 1'b1; smp_en = 1'b1;
        quiet(40*DIV, "R10 done stays idle");
        trig_in = 1'b0;
    endtask

    task automatic t_reset_clears();
        do_reset();
        @(negedge clk);
        trig_in = 1'b1; smp_en = 1'b1;
        repeat (DEPTH/2) @(negedge clk);
        trig_in = 1'b0;
        do_reset();
        smp_en = 1'b1;
        quiet(20*DIV, "R1 latch cleared by reset");
        capture(32'h0123_4567, 0, 1'b0);
        dump_check();
    endtask

    initial begin
        t_reset_state();
        t_capture_dump();
        t_done_quiet();
        t_reset_clears();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule